// File: doc/BRIEF.md
# Dual-Loop Synthesizer Divider Chain

This block holds the digital dividers of a two-loop frequency synthesizer. A reference divider cuts the crystal clock down to the comparison rate. It divides by 2048 or by 892, chosen by one control bit. That gives 5 kHz from a 10.24 MHz crystal, or 12.5 kHz from an 11.15 MHz crystal. Two independent 14-bit feedback counters divide the transmit and receive VCO signals. Each loop has its own phase-frequency detector, which compares the divided VCO against the shared reference and drives up/down pulses toward a charge pump outside this block.

A fourth divider produces the clock for the host controller. It divides by 2.5 for normal running, or by 80 while the host sleeps, and it can be switched off. All programming values come as parallel words from a configuration register block.

The whole block runs on the crystal clock. Each VCO enters as a one-cycle strobe per VCO period, already brought into the crystal domain. A new ratio never shortens the period already in progress: it is taken at the next terminal count.

Top module: `synth_divider_chain`

## Requirements
- R1: With `ref_sel_i`=0 the reference tick (`ref_tick_o`) comes once every 2048 clock cycles; with `ref_sel_i`=1 it comes once every 892 cycles. Each tick lasts one cycle.
- R2: After synchronous reset the reference ratio is 2048 and the feedback counters hold their default ratios (7000 transmit, 5000 receive). The host clock mode is off, and every output is low.
- R3: Each feedback counter raises its tick for one cycle after every N-th strobe of its VCO input, where N is its 14-bit programmed value. The two loops are independent.
- R4: A programmed feedback value of 0 or 1 divides by 2.
- R5: A changed reference select, feedback value or host mode is loaded only at the current terminal count, so the running period completes unchanged.
- R6: A detector's up output rises the cycle after a reference tick and holds until a feedback tick. Down behaves the same way with the roles swapped. Up and down are never high together: when both would be set, both clear.
- R7: Mode code 01 makes the host clock repeat the 5-cycle pattern high, low, high, low, low, which is an average ratio of 2.5.
- R8: Mode codes 10 and 11 give a host clock ratio of 80: 40 cycles high, then 40 cycles low.
- R9: Mode code 00 holds the host clock low. From the off state a new mode is taken on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_sel_i | input | 1 | Reference ratio select (0: 2048, 1: 892) |
| tx_div_i | input | 14 | Transmit feedback ratio |
| rx_div_i | input | 14 | Receive feedback ratio |
| tx_vco_i | input | 1 | Transmit VCO strobe, one cycle per VCO period |
| rx_vco_i | input | 1 | Receive VCO strobe, one cycle per VCO period |
| hclk_mode_i | input | 2 | Host clock mode (00 off, 01 ratio 2.5, 10/11 ratio 80) |
| ref_tick_o | output | 1 | Reference comparison tick |
| tx_fb_tick_o | output | 1 | Transmit feedback tick |
| rx_fb_tick_o | output | 1 | Receive feedback tick |
| tx_up_o | output | 1 | Transmit detector up pulse |
| tx_dn_o | output | 1 | Transmit detector down pulse |
| rx_up_o | output | 1 | Receive detector up pulse |
| rx_dn_o | output | 1 | Receive detector down pulse |
| host_clk_o | output | 1 | Divided host clock |

## Verification
The hardest case to reach is a reference tick and a feedback tick in the same cycle, while the detector is already holding one of its outputs. This is where the clear-both rule of R6 decides the result. The stimulus runs the 892 ratio against feedback ratios near the reference period and uses irregular VCO strobe patterns, so the two tick streams drift through each other many times. A second hard case is a ratio change in the middle of a period. The bench changes values well before the terminal count and follows the deferred load in its reference model.

// File: rtl/synth_div_pkg.sv
// Shared constants and types for the synthesizer divider chain.
package synth_div_pkg;
    localparam int LOOP_W        = 14;   // feedback counter width
    localparam int REF_W         = 12;   // reference counter width (holds 2048)
    localparam int REF_RATIO_LO  = 2048; // select = 0
    localparam int REF_RATIO_HI  = 892;  // select = 1
    localparam int HCLK_SLOW     = 80;   // sleep ratio of the host clock
    localparam int HCLK_FRAC_LEN = 5;    // two output periods (2 + 3 cycles)
    localparam int HCLK_CW       = $clog2(HCLK_SLOW);

    typedef enum logic [1:0] {
        HCLK_OFF    = 2'b00,
        HCLK_FRAC   = 2'b01,
        HCLK_SLOW_A = 2'b10,
        HCLK_SLOW_B = 2'b11
    } hclk_mode_e;
endpackage

// File: rtl/ref_divider.sv
// Reference divider: divides the crystal clock by RATIO_A or RATIO_B.
// Emits a one-cycle tick at each terminal count; the select is loaded
// only at the terminal count. Assumes both ratios fit in W bits.
module ref_divider #(
    parameter int W       = 12,
    parameter int RATIO_A = 2048,
    parameter int RATIO_B = 892
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    output logic tick_o
);
    localparam logic [W-1:0] RA = W'(RATIO_A);
    localparam logic [W-1:0] RB = W'(RATIO_B);

    logic [W-1:0] cnt_q;
    logic [W-1:0] ratio_q;

    // Count crystal cycles and reload the ratio at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ratio_q <= RA;
            tick_o  <= 1'b0;
        end else if (cnt_q == ratio_q - 1'b1) begin
            cnt_q   <= '0;
            ratio_q <= sel_i ? RB : RA;
            tick_o  <= 1'b1;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
            tick_o  <= 1'b0;
        end
    end
endmodule

// File: rtl/loop_counter.sv
// Programmable feedback counter of one loop. It counts VCO strobes and
// emits a one-cycle tick on every ratio-th strobe. A programmed value
// below 2 divides by 2. A new value is loaded at the terminal count.
// Assumes DEFAULT_RATIO >= 2.
module loop_counter #(
    parameter int W             = 14,
    parameter int DEFAULT_RATIO = 7000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vco_i,
    input  logic [W-1:0] prog_i,
    output logic         tick_o
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] ratio_q;
    logic [W-1:0] eff_ratio;

    // Clamp the programmed value to the smallest legal ratio.
    always_comb eff_ratio = (prog_i < W'(2)) ? W'(2) : prog_i;

    // Count strobes and reload the ratio on the terminal strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ratio_q <= W'(DEFAULT_RATIO);
            tick_o  <= 1'b0;
        end else begin
            tick_o <= 1'b0;
            if (vco_i) begin
                if (cnt_q == ratio_q - 1'b1) begin
                    cnt_q   <= '0;
                    ratio_q <= eff_ratio;
                    tick_o  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/phase_freq_det.sv
// Phase-frequency detector on tick inputs. A reference tick sets up and
// a feedback tick sets down. When both would be high, both clear.
// Assumes the inputs are one-cycle ticks in the same clock domain.
module phase_freq_det (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick_i,
    input  logic fb_tick_i,
    output logic up_o,
    output logic dn_o
);
    logic up_nxt;
    logic dn_nxt;

    // Merge new ticks into the held state, then apply the clear rule.
    always_comb begin
        up_nxt = up_o | ref_tick_i;
        dn_nxt = dn_o | fb_tick_i;
        if (up_nxt && dn_nxt) begin
            up_nxt = 1'b0;
            dn_nxt = 1'b0;
        end
    end

    // Register the detector state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_o <= 1'b0;
            dn_o <= 1'b0;
        end else begin
            up_o <= up_nxt;
            dn_o <= dn_nxt;
        end
    end
endmodule

// File: rtl/host_clk_div.sv
// Host clock divider. It is off, divides by 2.5 (alternating periods of 2
// and 3 cycles), or divides by 80 (40 cycles high, 40 low). A new mode is
// taken at the end of the current pattern, or on the next cycle when off.
module host_clk_div
    import synth_div_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    output logic       clk_o
);
    localparam logic [HCLK_CW-1:0] FRAC_LAST = HCLK_CW'(HCLK_FRAC_LEN - 1);
    localparam logic [HCLK_CW-1:0] SLOW_LAST = HCLK_CW'(HCLK_SLOW - 1);
    localparam logic [HCLK_CW-1:0] SLOW_HALF = HCLK_CW'(HCLK_SLOW / 2);

    hclk_mode_e         mode_q;
    logic [HCLK_CW-1:0] cnt_q;
    logic               is_slow;
    logic               wrap;

    // Decode the pattern end for the active mode.
    always_comb begin
        is_slow = (mode_q == HCLK_SLOW_A) || (mode_q == HCLK_SLOW_B);
        wrap    = ((mode_q == HCLK_FRAC) && (cnt_q == FRAC_LAST)) ||
                  (is_slow && (cnt_q == SLOW_LAST));
    end

    // Advance the phase counter and take a new mode at pattern boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= HCLK_OFF;
            cnt_q  <= '0;
        end else if (mode_q == HCLK_OFF || wrap) begin
            mode_q <= hclk_mode_e'(mode_i);
            cnt_q  <= '0;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // Derive the output level from the mode and phase.
    always_comb begin
        case (mode_q)
            HCLK_FRAC:   clk_o = (cnt_q == '0) || (cnt_q == HCLK_CW'(2));
            HCLK_SLOW_A,
            HCLK_SLOW_B: clk_o = (cnt_q < SLOW_HALF);
            default:     clk_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/synth_divider_chain.sv
// Top of the dual-loop synthesizer divider chain: one shared reference
// divider, two loops (feedback counter + detector) built by generate,
// and the host clock divider. Everything runs on the crystal clock.
// Assumes VCO strobes are already synchronized to clk.
module synth_divider_chain
    import synth_div_pkg::*;
#(
    parameter int TX_DEFAULT = 7000,
    parameter int RX_DEFAULT = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_sel_i,
    input  logic [LOOP_W-1:0] tx_div_i,
    input  logic [LOOP_W-1:0] rx_div_i,
    input  logic              tx_vco_i,
    input  logic              rx_vco_i,
    input  logic [1:0]        hclk_mode_i,
    output logic              ref_tick_o,
    output logic              tx_fb_tick_o,
    output logic              rx_fb_tick_o,
    output logic              tx_up_o,
    output logic              tx_dn_o,
    output logic              rx_up_o,
    output logic              rx_dn_o,
    output logic              host_clk_o
);
    localparam int N_LOOPS = 2;

    logic              ref_tick;
    logic [LOOP_W-1:0] div_arr [N_LOOPS];
    logic              vco_arr [N_LOOPS];
    logic              fb_arr  [N_LOOPS];
    logic              up_arr  [N_LOOPS];
    logic              dn_arr  [N_LOOPS];

    // Pack the per-loop ports into arrays (index 0 transmit, 1 receive).
    always_comb begin
        div_arr[0] = tx_div_i;
        div_arr[1] = rx_div_i;
        vco_arr[0] = tx_vco_i;
        vco_arr[1] = rx_vco_i;
    end

    ref_divider #(
        .W       (REF_W),
        .RATIO_A (REF_RATIO_LO),
        .RATIO_B (REF_RATIO_HI)
    ) u_ref (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (ref_sel_i),
        .tick_o (ref_tick)
    );

    for (genvar g = 0; g < N_LOOPS; g++) begin : g_loop
        loop_counter #(
            .W             (LOOP_W),
            .DEFAULT_RATIO ((g == 0) ? TX_DEFAULT : RX_DEFAULT)
        ) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .vco_i  (vco_arr[g]),
            .prog_i (div_arr[g]),
            .tick_o (fb_arr[g])
        );

        phase_freq_det u_pfd (
            .clk        (clk),
            .rst_n      (rst_n),
            .ref_tick_i (ref_tick),
            .fb_tick_i  (fb_arr[g]),
            .up_o       (up_arr[g]),
            .dn_o       (dn_arr[g])
        );
    end

    host_clk_div u_hclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (hclk_mode_i),
        .clk_o  (host_clk_o)
    );

    // Drive the per-loop outputs from the arrays.
    always_comb begin
        ref_tick_o   = ref_tick;
        tx_fb_tick_o = fb_arr[0];
        rx_fb_tick_o = fb_arr[1];
        tx_up_o      = up_arr[0];
        tx_dn_o      = dn_arr[0];
        rx_up_o      = up_arr[1];
        rx_dn_o      = dn_arr[1];
    end
endmodule

// File: rtl/synth_divider_chain_chk.sv
// Assertion checker for the divider chain, bound to the top module.
module synth_divider_chain_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_vco_i,
    input logic rx_vco_i,
    input logic ref_tick_o,
    input logic tx_fb_tick_o,
    input logic rx_fb_tick_o,
    input logic tx_up_o,
    input logic tx_dn_o,
    input logic rx_up_o,
    input logic rx_dn_o
);
    // R1
    ref_tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick_o |=> !ref_tick_o);

    // R3
    tx_fb_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fb_tick_o |-> $past(tx_vco_i));

    // R3
    rx_fb_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fb_tick_o |-> $past(rx_vco_i));

    // R6
    tx_updn_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_up_o && tx_dn_o));

    // R6
    rx_updn_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_up_o && rx_dn_o));

    // R6
    tx_up_after_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_up_o) |-> $past(ref_tick_o));

    // R6
    rx_dn_after_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_dn_o) |-> $past(rx_fb_tick_o));
endmodule

bind synth_divider_chain synth_divider_chain_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_vco_i     (tx_vco_i),
    .rx_vco_i     (rx_vco_i),
    .ref_tick_o   (ref_tick_o),
    .tx_fb_tick_o (tx_fb_tick_o),
    .rx_fb_tick_o (rx_fb_tick_o),
    .tx_up_o      (tx_up_o),
    .tx_dn_o      (tx_dn_o),
    .rx_up_o      (rx_up_o),
    .rx_dn_o      (rx_dn_o)
);

// File: tb/synth_divider_chain_bench.sv
// Bench: a behavioural reference model is stepped on each rising edge and
// compared with the design on each falling edge.
module synth_divider_chain_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_sel_i = 1'b0;
    logic [13:0] tx_div_i = 14'd3;
    logic [13:0] rx_div_i = 14'd5;
    logic        tx_vco_i = 1'b0;
    logic        rx_vco_i = 1'b0;
    logic [1:0]  hclk_mode_i = 2'b01;
    logic        ref_tick_o, tx_fb_tick_o, rx_fb_tick_o;
    logic        tx_up_o, tx_dn_o, rx_up_o, rx_dn_o, host_clk_o;

    int    n_checks = 0;
    int    n_errors = 0;
    int    cycles   = 0;
    bit    cmp_en   = 1'b0;
    int    tx_pct   = 100;
    int    rx_pct   = 100;
    string fb_tag   = "R5";
    string host_tag = "R7";

    // reference model state
    int m_ref_cnt = 0, m_ref_ratio = 2048; bit m_ref_tick = 0;
    int m_cnt[2] = '{0, 0};
    int m_ratio[2] = '{7000, 5000};
    bit m_fb[2] = '{0, 0};
    bit m_up[2] = '{0, 0};
    bit m_dn[2] = '{0, 0};
    int m_hmode = 0, m_hcnt = 0;

    always #2 clk = ~clk;

    synth_divider_chain u_synth_divider_chain (
        .clk(clk), .rst_n(rst_n), .ref_sel_i(ref_sel_i),
        .tx_div_i(tx_div_i), .rx_div_i(rx_div_i),
        .tx_vco_i(tx_vco_i), .rx_vco_i(rx_vco_i), .hclk_mode_i(hclk_mode_i),
        .ref_tick_o(ref_tick_o), .tx_fb_tick_o(tx_fb_tick_o),
        .rx_fb_tick_o(rx_fb_tick_o), .tx_up_o(tx_up_o), .tx_dn_o(tx_dn_o),
        .rx_up_o(rx_up_o), .rx_dn_o(rx_dn_o), .host_clk_o(host_clk_o));

    task automatic check(input bit act, input bit exp, input string tag, input string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", tag, what, cycles, act, exp);
        end
    endtask

    function automatic bit model_host();
        if (m_hmode == 1) return (m_hcnt == 0) || (m_hcnt == 2);
        if (m_hmode >= 2) return m_hcnt < 40;
        return 1'b0;
    endfunction

    // Step the model with the inputs stable since the last falling edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_ref_cnt = 0; m_ref_ratio = 2048; m_ref_tick = 0;
            m_cnt = '{0, 0}; m_ratio = '{7000, 5000};
            m_fb = '{0, 0}; m_up = '{0, 0}; m_dn = '{0, 0};
            m_hmode = 0; m_hcnt = 0;
        end else begin
            for (int k = 0; k < 2; k++) begin
                bit u, d;
                u = m_up[k] | m_ref_tick;
                d = m_dn[k] | m_fb[k];
                if (u && d) begin u = 0; d = 0; end
                m_up[k] = u; m_dn[k] = d;
            end
            if (m_ref_cnt == m_ref_ratio - 1) begin
                m_ref_cnt = 0; m_ref_tick = 1;
                m_ref_ratio = ref_sel_i ? 892 : 2048;
            end else begin
                m_ref_cnt++; m_ref_tick = 0;
            end
            for (int k = 0; k < 2; k++) begin
                bit v;
                int p;
                v = (k == 0) ? tx_vco_i : rx_vco_i;
                p = (k == 0) ? int'(tx_div_i) : int'(rx_div_i);
                m_fb[k] = 0;
                if (v) begin
                    if (m_cnt[k] == m_ratio[k] - 1) begin
                        m_cnt[k] = 0; m_fb[k] = 1;
                        m_ratio[k] = (p < 2) ? 2 : p;
                    end else m_cnt[k]++;
                end
            end
            if (m_hmode == 0 || (m_hmode == 1 && m_hcnt == 4) ||
                (m_hmode >= 2 && m_hcnt == 79)) begin
                m_hmode = int'(hclk_mode_i); m_hcnt = 0;
            end else m_hcnt++;
        end
    end

    // Compare outputs and drive the VCO strobes away from the rising edge.
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            check(ref_tick_o, m_ref_tick, "R1", "ref_tick");
            check(tx_fb_tick_o, m_fb[0], fb_tag, "tx_fb_tick");
            check(rx_fb_tick_o, m_fb[1], fb_tag, "rx_fb_tick");
            check(tx_up_o, m_up[0], "R6", "tx_up");
            check(tx_dn_o, m_dn[0], "R6", "tx_dn");
            check(rx_up_o, m_up[1], "R6", "rx_up");
            check(rx_dn_o, m_dn[1], "R6", "rx_dn");
            check(host_clk_o, model_host(), host_tag, "host_clk");
        end
        tx_vco_i <= ($urandom_range(99) < tx_pct);
        rx_vco_i <= ($urandom_range(99) < rx_pct);
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        wait (cycles > 190000);
        n_checks++; n_errors++;
        $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 190000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        run(5);
        // R2: outputs low after reset
        check(ref_tick_o, 1'b0, "R2", "ref_tick in reset");
        check(tx_up_o | tx_dn_o | rx_up_o | rx_dn_o, 1'b0, "R2", "detectors in reset");
        check(tx_fb_tick_o | rx_fb_tick_o, 1'b0, "R2", "fb ticks in reset");
        check(host_clk_o, 1'b0, "R2", "host clock in reset");
        @(negedge clk); rst_n = 1'b1; cmp_en = 1'b1;
        // R5/R2: default ratios hold until the first terminal count; 2.5 mode (R7)
        run(8000);
        // R4: values below 2 divide by 2
        fb_tag = "R4"; tx_div_i = 14'd0; rx_div_i = 14'd1;
        run(300);
        // R3 + R6: 892 reference, ratios near the reference period, irregular strobes; R8 slow host clock
        fb_tag = "R3"; host_tag = "R8";
        ref_sel_i = 1'b1; tx_div_i = 14'd700; rx_div_i = 14'd1100;
        hclk_mode_i = 2'b10; tx_pct = 80; rx_pct = 95;
        run(9000);
        hclk_mode_i = 2'b11;
        run(400);
        // R9: off mode holds the host clock low
        host_tag = "R9"; hclk_mode_i = 2'b00;
        run(300);
        hclk_mode_i = 2'b01; host_tag = "R7";
        run(100);
        // R5: select change mid-period, back to 2048
        fb_tag = "R5"; ref_sel_i = 1'b0; tx_div_i = 14'd9; rx_div_i = 14'd2;
        run(4500);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule